// File: doc/BRIEF.md
# Predicated Multi-Width SIMD Lane Unit

This block is one pipeline stage of a vector datapath. It takes two vector operands, an old destination vector and a predicate word with one bit per vector byte. It applies an element-wise add, subtract or pass-through to the operands. The element width is chosen per operation from 8, 16, 32 or 64 bits. The vector width is a parameter and must be a power of two between 128 and 2048 bits.

Each element looks at one predicate bit: the bit at the lowest byte index of that element. The other predicate bits covering the element's bytes are ignored. A predicate word that is fully set therefore enables every element at any width. An element whose bit is clear is inactive. An inactive element either keeps the old destination value (merging) or is written with zeros, depending on a mode input.

The result is registered. It appears with a valid flag one clock after the input valid.

Top module: `pred_simd_lane`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid and result are cleared to zero.
- R2: out_valid equals in_valid delayed by one clock. result loads only on a clock where in_valid is 1 and otherwise holds its value.
- R3: With op = 2'b00 (add), each active element becomes (a + b) modulo 2^width, and no carry passes into the next element.
- R4: With op = 2'b01 (subtract), each active element becomes (a - b) modulo 2^width, and no borrow passes into the next element.
- R5: With op = 2'b10 or 2'b11 (pass-through), each active element becomes the src_a element.
- R6: Element e of size S bytes is active exactly when pred[e*S] is 1. The pred bits e*S+1 to e*S+S-1 have no effect.
- R7: With zero_mode = 0, each inactive element takes the dst_old element.
- R8: With zero_mode = 1, each inactive element is all zeros.
- R9: esize encodes the element width: 2'b00 is 8-bit, 2'b01 is 16-bit, 2'b10 is 32-bit, 2'b11 is 64-bit.
- R10: An all-ones pred makes every element active at each of the four widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operation is valid this cycle |
| op | input | 2 | 00 add, 01 subtract, 1x pass-through |
| esize | input | 2 | Element width select (R9) |
| zero_mode | input | 1 | 1 zeroes inactive elements, 0 merges dst_old |
| src_a | input | VEC_BITS | First operand |
| src_b | input | VEC_BITS | Second operand |
| dst_old | input | VEC_BITS | Previous destination value, used for merging |
| pred | input | VEC_BITS/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result is valid |
| result | output | VEC_BITS | Registered result vector |

## Verification
The bench builds the unit with VEC_BITS = 128, the smallest legal width. At that width a 64-bit lane covers half the vector. One check can therefore show both a full 8-byte carry chain inside an element and the carry being cut at the element boundary. The 16-bit predicate is small enough to write out directly, so the table entries can place junk bits at non-lowest positions of every group width.

// File: rtl/simd_lane_pkg.sv
// Package: shared encodings for the predicated SIMD lane unit.
// Assumes: op and esize arrive on 2-bit plain ports and are decoded here.
package simd_lane_pkg;
    typedef enum logic [1:0] {
        ES_8  = 2'b00,
        ES_16 = 2'b01,
        ES_32 = 2'b10,
        ES_64 = 2'b11
    } lane_esize_e;

    localparam logic [1:0] OPC_ADD = 2'b00;
    localparam logic [1:0] OPC_SUB = 2'b01;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/lane_enable_expand.sv
// Module: lane_enable_expand
// Turns the byte-granular predicate into a per-byte lane enable. Each byte
// copies the predicate bit at the lowest byte index of its element.
// Assumes: NBYTES is a multiple of 8, so every 64-bit group lies inside the vector.
module lane_enable_expand
    import simd_lane_pkg::*;
#(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES-1:0] pred,
    input  logic [1:0]        esize,
    output logic [NBYTES-1:0] byte_en
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        localparam int BASE2 = i - (i % 2);
        localparam int BASE4 = i - (i % 4);
        localparam int BASE8 = i - (i % 8);
        // Pick this byte's governing predicate bit for the selected width.
        always_comb begin
            unique case (lane_esize_e'(esize))
                ES_8:    byte_en[i] = pred[i];
                ES_16:   byte_en[i] = pred[BASE2];
                ES_32:   byte_en[i] = pred[BASE4];
                default: byte_en[i] = pred[BASE8];
            endcase
        end
    end
endmodule

// File: rtl/segmented_addsub.sv
// Module: segmented_addsub
// Adds or subtracts byte by byte along one carry chain. The chain restarts at
// every element boundary, so nothing carries between elements.
// Pass-through ops return src_a unchanged.
// Assumes: esize follows the R9 encoding.
module segmented_addsub
    import simd_lane_pkg::*;
#(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] src_a,
    input  logic [NBYTES*8-1:0] src_b,
    input  logic [1:0]          op,
    input  logic [1:0]          esize,
    output logic [NBYTES*8-1:0] arith
);
    localparam int VB = NBYTES * BYTE_W;

    logic        is_sub;
    logic        is_arith;
    logic [2:0]  grp_mask;

    // Decode the op and the in-element byte index mask.
    always_comb begin
        is_sub   = (op == OPC_SUB);
        is_arith = (op == OPC_ADD) || (op == OPC_SUB);
        grp_mask = 3'((4'd1 << esize) - 4'd1);
    end

    // Ripple through the bytes, reloading the carry at each element start.
    always_comb begin
        logic       cy;
        logic [8:0] s;
        cy    = 1'b0;
        arith = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if ((3'(i) & grp_mask) == 3'd0) cy = is_sub;
            s  = {1'b0, src_a[i*8 +: 8]} + {1'b0, src_b[i*8 +: 8] ^ {8{is_sub}}} + 9'(cy);
            cy = s[8];
            arith[i*8 +: 8] = is_arith ? s[7:0] : src_a[i*8 +: 8];
        end
    end

    logic unused_vb;
    assign unused_vb = (VB == 0);
endmodule

// File: rtl/lane_merge_select.sv
// Module: lane_merge_select
// Chooses each output byte. Active bytes take the arithmetic result. Inactive
// bytes take the old destination or zero, as zero_mode selects.
// Assumes: byte_en is already expanded to element granularity.
module lane_merge_select #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] arith,
    input  logic [NBYTES*8-1:0] dst_old,
    input  logic [NBYTES-1:0]   byte_en,
    input  logic                zero_mode,
    output logic [NBYTES*8-1:0] merged
);
    for (genvar i = 0; i < NBYTES; i++) begin : g_sel
        // Per-byte three-way choice.
        always_comb begin
            if (byte_en[i])     merged[i*8 +: 8] = arith[i*8 +: 8];
            else if (zero_mode) merged[i*8 +: 8] = 8'h00;
            else                merged[i*8 +: 8] = dst_old[i*8 +: 8];
        end
    end
endmodule

// File: rtl/pred_simd_lane.sv
// Module: pred_simd_lane (top)
// A predicated element-wise add, subtract or pass stage with a one-cycle
// registered output.
// Assumes: VEC_BITS is a power of two from 128 to 2048. The checker tests this.
module pred_simd_lane
    import simd_lane_pkg::*;
#(
    parameter int VEC_BITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [1:0]            op,
    input  logic [1:0]            esize,
    input  logic                  zero_mode,
    input  logic [VEC_BITS-1:0]   src_a,
    input  logic [VEC_BITS-1:0]   src_b,
    input  logic [VEC_BITS-1:0]   dst_old,
    input  logic [VEC_BITS/8-1:0] pred,
    output logic                  out_valid,
    output logic [VEC_BITS-1:0]   result
);
    localparam int NBYTES = VEC_BITS / BYTE_W;

    logic [NBYTES-1:0]   byte_en;
    logic [VEC_BITS-1:0] arith;
    logic [VEC_BITS-1:0] merged;

    lane_enable_expand #(.NBYTES(NBYTES)) u_en (
        .pred    (pred),
        .esize   (esize),
        .byte_en (byte_en)
    );

    segmented_addsub #(.NBYTES(NBYTES)) u_alu (
        .src_a (src_a),
        .src_b (src_b),
        .op    (op),
        .esize (esize),
        .arith (arith)
    );

    lane_merge_select #(.NBYTES(NBYTES)) u_sel (
        .arith     (arith),
        .dst_old   (dst_old),
        .byte_en   (byte_en),
        .zero_mode (zero_mode),
        .merged    (merged)
    );

    // Output register: clears on reset and loads on valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= merged;
        end
    end
endmodule

// File: rtl/pred_simd_lane_chk.sv
// Module: pred_simd_lane_chk
// Property checker for pred_simd_lane, attached with bind.
// Assumes: it sees only the top's ports.
module pred_simd_lane_chk #(
    parameter int VEC_BITS = 256
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [1:0]            op,
    input logic [1:0]            esize,
    input logic                  zero_mode,
    input logic [VEC_BITS-1:0]   src_a,
    input logic [VEC_BITS-1:0]   src_b,
    input logic [VEC_BITS-1:0]   dst_old,
    input logic [VEC_BITS/8-1:0] pred,
    input logic                  out_valid,
    input logic [VEC_BITS-1:0]   result
);
    // Parameter legality check at start-up.
    initial begin
        a_param_width: assert (VEC_BITS >= 128 && VEC_BITS <= 2048 &&
                               (VEC_BITS & (VEC_BITS - 1)) == 0)
            else $error("VEC_BITS not a legal vector width");
    end

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    a_r8_all_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == '0 && zero_mode) |=> result == '0);

    a_r7_all_off_merge: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pred == '0 && !zero_mode) |=> result == $past(dst_old));

    a_r10_full_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && &pred && op[1]) |=> result == $past(src_a));

    a_r3_byte_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && esize == 2'b00 && pred[0])
        |=> result[7:0] == 8'($past(src_a[7:0]) + $past(src_b[7:0])));

    logic unused_sig;
    assign unused_sig = ^{src_b[VEC_BITS-1:8]};
endmodule

bind pred_simd_lane pred_simd_lane_chk #(.VEC_BITS(VEC_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .esize     (esize),
    .zero_mode (zero_mode),
    .src_a     (src_a),
    .src_b     (src_b),
    .dst_old   (dst_old),
    .pred      (pred),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/pred_simd_lane_tb_top.sv
// Bench for pred_simd_lane at VEC_BITS = 128.
module pred_simd_lane_tb_top;
    localparam int VB = 128;
    localparam int NB = VB / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op = 2'b00;
    logic [1:0]    esize = 2'b00;
    logic          zero_mode = 1'b0;
    logic [VB-1:0] src_a = '0;
    logic [VB-1:0] src_b = '0;
    logic [VB-1:0] dst_old = '0;
    logic [NB-1:0] pred = '0;
    logic          out_valid;
    logic [VB-1:0] result;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    pred_simd_lane #(.VEC_BITS(VB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
        .zero_mode(zero_mode), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .pred(pred), .out_valid(out_valid), .result(result)
    );

    // Table entry layout: {op[1:0], esize[1:0], zero_mode, pred[15:0], seed[31:0]}.
    localparam int NT = 16;
    localparam logic [52:0] TBL [NT] = '{
        {2'b00, 2'b00, 1'b0, 16'hA5C3, 32'h0000_1001},
        {2'b00, 2'b01, 1'b1, 16'hFAFA, 32'h0000_2002},  // junk in odd bits
        {2'b00, 2'b10, 1'b0, 16'hEEE1, 32'h0000_3003},
        {2'b00, 2'b11, 1'b1, 16'hFE01, 32'h0000_4004},
        {2'b01, 2'b00, 1'b1, 16'h3C96, 32'h0000_5005},
        {2'b01, 2'b01, 1'b0, 16'h5AA5, 32'h0000_6006},
        {2'b01, 2'b10, 1'b1, 16'h1EF0, 32'h0000_7007},
        {2'b01, 2'b11, 1'b0, 16'h01FE, 32'h0000_8008},
        {2'b10, 2'b00, 1'b0, 16'h0F0F, 32'h0000_9009},
        {2'b10, 2'b01, 1'b1, 16'hCCCC, 32'h0000_A00A},
        {2'b11, 2'b10, 1'b0, 16'h7771, 32'h0000_B00B},
        {2'b11, 2'b11, 1'b1, 16'hFFFE, 32'h0000_C00C},
        {2'b00, 2'b00, 1'b1, 16'hFFFF, 32'h0000_D00D},
        {2'b01, 2'b01, 1'b0, 16'hFFFF, 32'h0000_E00E},
        {2'b00, 2'b10, 1'b1, 16'hFFFF, 32'h0000_F00F},
        {2'b01, 2'b11, 1'b0, 16'hFFFF, 32'h0001_0010}
    };

    function automatic logic [VB-1:0] gen_vec(input logic [31:0] seed);
        logic [31:0]   s;
        logic [VB-1:0] v;
        s = seed;
        v = '0;
        for (int k = 0; k < VB / 32; k++) begin
            s = s * 32'd1664525 + 32'd1013904223;
            v[k*32 +: 32] = s;
        end
        return v;
    endfunction

    // Behavioural model written from R3 to R10.
    function automatic logic [VB-1:0] model(input logic [1:0] f_op, input logic [1:0] f_es,
            input logic f_zm, input logic [VB-1:0] a, input logic [VB-1:0] b,
            input logic [VB-1:0] d, input logic [NB-1:0] p);
        int          eb;
        int          bits;
        logic [63:0] m;
        logic [63:0] la;
        logic [63:0] lb;
        logic [63:0] ld;
        logic [63:0] r;
        logic [VB-1:0] o;
        eb   = 1 << f_es;
        bits = 8 * eb;
        m    = (bits == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << bits) - 64'd1);
        o    = '0;
        for (int e = 0; e < NB / eb; e++) begin
            la = 64'(a >> (e * bits)) & m;
            lb = 64'(b >> (e * bits)) & m;
            ld = 64'(d >> (e * bits)) & m;
            if (f_op == 2'b00)      r = (la + lb) & m;
            else if (f_op == 2'b01) r = (la - lb) & m;
            else                    r = la;
            if (!p[e * eb]) r = f_zm ? 64'd0 : ld;
            o = o | (VB'(r) << (e * bits));
        end
        return o;
    endfunction

    task automatic check(input string tag, input logic [VB-1:0] got, input logic [VB-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drive one valid operation, then sample after the register edge.
    task automatic run_op(input logic [1:0] o, input logic [1:0] es, input logic zm,
            input logic [VB-1:0] a, input logic [VB-1:0] b, input logic [VB-1:0] d,
            input logic [NB-1:0] p);
        @(negedge clk);
        op = o; esize = es; zero_mode = zm;
        src_a = a; src_b = b; dst_old = d; pred = p;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    logic [VB-1:0] held;

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1: the outputs are cleared during reset.
        check("R1 reset valid", VB'(out_valid), '0);
        check("R1 reset result", result, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R3 R4 R5 R6 R7 R8 R9 R10 against the model.
        for (int t = 0; t < NT; t++) begin
            logic [VB-1:0] a;
            logic [VB-1:0] b;
            logic [VB-1:0] d;
            a = gen_vec(TBL[t][31:0]);
            b = gen_vec(TBL[t][31:0] ^ 32'h5555_AAAA);
            d = gen_vec(TBL[t][31:0] + 32'd77);
            run_op(TBL[t][52:51], TBL[t][50:49], TBL[t][48], a, b, d, TBL[t][47:32]);
            check($sformatf("R6 R9 table %0d", t), result,
                  model(TBL[t][52:51], TBL[t][50:49], TBL[t][48], a, b, d, TBL[t][47:32]));
            check($sformatf("R2 valid table %0d", t), VB'(out_valid), VB'(1));
        end

        // R3: 8-bit wrap; the carry does not reach byte 1.
        run_op(2'b00, 2'b00, 1'b0, VB'(128'h00FF), VB'(128'h0001), '0, '1);
        check("R3 8-bit wrap", result, '0);
        // R9: the same operands as 16-bit elements carry into byte 1.
        run_op(2'b00, 2'b01, 1'b0, VB'(128'h00FF), VB'(128'h0001), '0, '1);
        check("R9 16-bit carry", result, VB'(128'h0100));
        // R3: a 64-bit element carries through all 8 bytes and stops at the boundary.
        run_op(2'b00, 2'b11, 1'b0, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, VB'(128'h1), '0, '1);
        check("R3 64-bit boundary", result, '0);
        // R4: an 8-bit borrow stays in its element.
        run_op(2'b01, 2'b00, 1'b0, '0, VB'(128'h01), '0, '1);
        check("R4 8-bit borrow", result, VB'(128'hFF));
        // R4: a 32-bit borrow across bytes.
        run_op(2'b01, 2'b10, 1'b0, VB'(128'h0000_0000_0000_0100), VB'(128'h1), '0, '1);
        check("R4 32-bit borrow", result, VB'(128'h0000_0000_0000_00FF));
        // R6: 64-bit elements with junk above bit 0 of each group: both inactive, merge.
        run_op(2'b10, 2'b11, 1'b0, '1, '0, {64'h1111, 64'h2222}, 16'hFEFE);
        check("R6 junk ignored R7 merge", result, {64'h1111, 64'h2222});
        // R6: only the group base bits are set: both elements active.
        run_op(2'b10, 2'b11, 1'b1, {64'hAB, 64'hCD}, '0, '0, 16'h0101);
        check("R6 base bits R5 pass", result, {64'hAB, 64'hCD});
        // R8: zero mode with only element 1 active (32-bit, pred bit 4).
        run_op(2'b11, 2'b10, 1'b1, '1, '0, '1, 16'h0010);
        check("R8 zero inactive", result, VB'(128'hFFFF_FFFF_0000_0000));
        // R10: all-ones pred with 64-bit pass.
        run_op(2'b10, 2'b11, 1'b0, gen_vec(32'h99), '0, '0, '1);
        check("R10 full pred", result, gen_vec(32'h99));

        // R2: an idle cycle clears valid and holds the result.
        held = result;
        @(negedge clk);
        src_a = '0; pred = '1; op = 2'b10;
        @(negedge clk);
        check("R2 idle valid low", VB'(out_valid), '0);
        check("R2 result held", result, held);

        // R1: reset mid-run clears the outputs again.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", result, '0);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule